// File: doc/BRIEF.md
# UART DMA Request Line Generator

This block drives the two active-low DMA request lines of a FIFO-based UART. One line asks for reads from the receive side and the other asks for writes to the transmit side. It takes the receive occupancy, the receive trigger-reached and character-timeout flags, the transmit occupancy, the FIFO enable bit and the DMA mode bit. From these it produces `rx_req_n` and `tx_req_n`, each registered, so each follows its inputs by one clock.

Two signalling schemes exist. The single-transfer scheme applies when FIFOs are disabled, or when FIFOs are enabled with the mode bit clear. In this scheme each line simply reflects whether there is work to do. The multi-transfer scheme applies only when both bits are set, and it adds hysteresis. The receive request starts at the trigger level or on a timeout and lasts until the receive side is drained. The transmit request starts when the transmit FIFO is empty and lasts until it is full.

Top module: `uart_dma_req`

## Requirements
- R1: While `rst` is high, both `rx_req_n` and `tx_req_n` are 1 (inactive) on the clock after each edge.
- R2: Multi-transfer signalling is used only when `fifo_en`=1 and `dma_multi`=1. With `fifo_en`=0, `dma_multi` has no effect and single-transfer behaviour applies.
- R3: Single-transfer: `rx_req_n` is 0 when `rx_count`≠0 and 1 when `rx_count`=0.
- R4: Multi-transfer: `rx_req_n` falls to 0 when `rx_trig` or `rx_tout` is 1 while `rx_count`≠0.
- R5: Multi-transfer: once `rx_req_n` is 0, it stays 0 while `rx_count`≠0, even after the trigger and timeout flags drop. It returns to 1 when `rx_count`=0.
- R6: Single-transfer: `tx_req_n` is 0 when `tx_count`=0 and 1 otherwise.
- R7: Multi-transfer: `tx_req_n` falls to 0 when `tx_count`=0 and rises to 1 when `tx_count`=DEPTH. For counts strictly between 0 and DEPTH it holds its level.
- R8: Every output change appears on the first rising edge after the input change that causes it, so the latency is one cycle.
- R9: Multi-transfer: a trigger or timeout flag with `rx_count`=0 does not activate `rx_req_n`. An empty receive side takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | FIFO enable control bit |
| dma_multi | input | 1 | DMA mode select (1 = multi-transfer) |
| rx_count | input | $clog2(DEPTH+1) | Characters held on the receive side |
| rx_trig | input | 1 | Receive trigger level reached |
| rx_tout | input | 1 | Character timeout reached |
| tx_count | input | $clog2(DEPTH+1) | Characters held in the transmit FIFO |
| rx_req_n | output | 1 | Receive DMA request, active low |
| tx_req_n | output | 1 | Transmit DMA request, active low |

## Verification
The assertions assume that both occupancy inputs never exceed DEPTH. They also assume that the flags and counts are steady across each clock edge. The stimulus changes inputs only on the falling edge and draws every count from 0 to DEPTH. The trigger and timeout flags are sometimes raised with an empty receive side on purpose, so that the priority of emptiness is exercised rather than assumed away.

// File: rtl/uart_dma_req.sv
module uart_dma_req #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          dma_multi,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_trig,
  input  logic          rx_tout,
  input  logic [CW-1:0] tx_count,
  output logic          rx_req_n,
  output logic          tx_req_n
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic multi, rx_empty, tx_empty, tx_full;
  logic rx_act, tx_act, rx_act_d, tx_act_d;

  assign multi    = fifo_en & dma_multi;
  assign rx_empty = (rx_count == '0);
  assign tx_empty = (tx_count == '0);
  assign tx_full  = (tx_count == FULL);

  always_comb begin
    if (!multi)                  rx_act_d = !rx_empty;
    else if (rx_empty)           rx_act_d = 1'b0;
    else if (rx_trig || rx_tout) rx_act_d = 1'b1;
    else                         rx_act_d = rx_act;

    if (!multi)        tx_act_d = tx_empty;
    else if (tx_full)  tx_act_d = 1'b0;
    else if (tx_empty) tx_act_d = 1'b1;
    else               tx_act_d = tx_act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_act <= 1'b0;
      tx_act <= 1'b0;
    end else begin
      rx_act <= rx_act_d;
      tx_act <= tx_act_d;
    end
  end

  assign rx_req_n = ~rx_act;
  assign tx_req_n = ~tx_act;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (rx_req_n && tx_req_n));

  p_sgl_rx_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (!(fifo_en && dma_multi)) |=> (rx_req_n == $past(rx_count == '0)));

  p_multi_rx_start_r4: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && dma_multi && rx_count != '0 && (rx_trig || rx_tout)) |=> !rx_req_n);

  p_multi_rx_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && dma_multi && rx_count != '0 && !rx_trig && !rx_tout) |=> $stable(rx_req_n));

  p_multi_rx_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && dma_multi && rx_count == '0) |=> rx_req_n);

  p_sgl_tx_follow_r6: assert property (@(posedge clk) disable iff (rst)
    (!(fifo_en && dma_multi)) |=> (tx_req_n == $past(tx_count != '0)));

  p_tx_full_off_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_count == FULL) |=> tx_req_n);

  p_multi_tx_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && dma_multi && tx_count != '0 && tx_count != FULL) |=> $stable(tx_req_n));

endmodule

// File: tb/tb_uart_dma_req.sv
module tb_uart_dma_req;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b0, dma_multi = 1'b0, rx_trig = 1'b0, rx_tout = 1'b0;
  logic [CW-1:0] rx_count = '0, tx_count = '0;
  logic rx_req_n, tx_req_n;

  uart_dma_req #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_multi(dma_multi),
    .rx_count(rx_count), .rx_trig(rx_trig), .rx_tout(rx_tout),
    .tx_count(tx_count), .rx_req_n(rx_req_n), .tx_req_n(tx_req_n));

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  bit started = 0, done = 0;
  string tag = "R1";
  int m_rx_on = 0, m_tx_on = 0;

  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (rst) begin
      m_rx_on = 0; m_tx_on = 0;
    end else if (!(fifo_en && dma_multi)) begin
      m_rx_on = (rx_count > 0);
      m_tx_on = (tx_count == 0);
    end else begin
      if (int'(rx_count) == 0) m_rx_on = 0;
      else if (rx_trig || rx_tout) m_rx_on = 1;
      if (int'(tx_count) == DEPTH) m_tx_on = 0;
      else if (int'(tx_count) == 0) m_tx_on = 1;
    end
  end

  always @(negedge clk) if (started && !done) begin
    compared++;
    if (rx_req_n !== (m_rx_on == 0)) begin
      mismatched++;
      $display("FAIL %s rx_req_n actual=%b expected=%0d", tag, rx_req_n, m_rx_on == 0);
    end
    compared++;
    if (tx_req_n !== (m_tx_on == 0)) begin
      mismatched++;
      $display("FAIL %s tx_req_n actual=%b expected=%0d", tag, tx_req_n, m_tx_on == 0);
    end
  end

  task automatic drive(input string t, input bit fe, input bit dm, input int rc,
                       input bit tg, input bit to, input int tc, input int n);
    @(negedge clk);
    tag = t; fifo_en = fe; dma_multi = dm;
    rx_count = CW'(rc); rx_trig = tg; rx_tout = to; tx_count = CW'(tc);
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    drive("R1", 1, 1, 5, 1, 0, 0, 3);
    @(negedge clk); rst = 1'b0;
    drive("R3", 0, 0, 0, 0, 0, 3, 2);
    drive("R3", 0, 0, 1, 0, 0, 3, 2);
    drive("R8", 0, 0, 7, 0, 0, 0, 1);
    drive("R3", 1, 0, 0, 0, 0, 0, 2);
    drive("R6", 1, 0, 0, 0, 0, 1, 2);
    drive("R6", 0, 0, 2, 0, 0, DEPTH, 2);
    drive("R2", 0, 1, 4, 0, 0, 0, 2);
    drive("R2", 0, 1, 0, 1, 0, 5, 2);
    drive("R4", 1, 1, 3, 0, 0, 5, 3);
    drive("R4", 1, 1, 4, 1, 0, 5, 2);
    drive("R5", 1, 1, 3, 0, 0, 5, 3);
    drive("R5", 1, 1, 1, 0, 0, 5, 2);
    drive("R5", 1, 1, 0, 0, 0, 5, 2);
    drive("R9", 1, 1, 0, 1, 1, 5, 3);
    drive("R4", 1, 1, 2, 0, 1, 0, 2);
    drive("R7", 1, 1, 2, 0, 0, 8, 3);
    drive("R7", 1, 1, 0, 0, 0, DEPTH, 2);
    drive("R7", 1, 1, 0, 0, 0, 9, 3);
    drive("R7", 1, 1, 0, 0, 0, 0, 2);
    drive("R2", 0, 1, 3, 0, 0, 9, 2);
    drive("R1", 1, 1, 6, 1, 0, 0, 1);
    rst = 1'b1;
    drive("R1", 1, 1, 6, 1, 0, 0, 3);
    rst = 1'b0;
    drive("R8", 1, 1, 6, 1, 0, 0, 2);
    for (int i = 0; i < 40; i++)
      drive("R8", (i % 5) != 0, (i % 3) != 0, (i * 7) % (DEPTH + 1),
            (i % 4) == 1, (i % 6) == 2, (i * 5) % (DEPTH + 1), 1 + (i % 3));
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    if (!done) begin
      done = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule